// File: doc/BRIEF.md
# Activity Monitor Counter Bank

A bank of free-running 64-bit activity counters that a processor core keeps to report its own utilisation to system management software. Four fixed counters track core clock cycles, constant-rate ticks, retired instructions and cycles lost to last-level cache misses. A parameterised group of up to sixteen auxiliary counters each follows one event qualifier. Counting runs only while the global enable is set and the core is not parked in a wait-for-interrupt or wait-for-event state.

Software reaches the counters through a single-request register port. Every request carries the privilege level of the requester and is checked against two delegation bits. Requests that are not allowed, or that address nothing, produce a one-cycle fault strobe in place of data. Reads return zero while counting is disabled. The highest privilege level may write any counter, so firmware can save the bank before power-off and restore it afterwards.

The response path is a small state machine whose state encodes the outcome of the previous cycle's request. Its states are RS_IDLE (no request last cycle), RS_READ (a granted read, data valid), RS_WRITE (a granted write, acknowledged) and RS_DENY (a refused or unmapped request, fault raised). Every cycle the machine moves to the state chosen by the current request: no request goes to RS_IDLE, a refused or unmapped request goes to RS_DENY, a granted write goes to RS_WRITE and a granted read goes to RS_READ. Any state can reach any other state in one step.

Top module: `actmon_bank`

## Requirements
- R1: After reset every counter is zero and `rsp_vld`, `rsp_fault` and `rsp_data` are all zero.
- R2: The counters advance only when `cnt_en` is 1 and `wait_st` is 0. While counting runs, the core-cycle counter (address 0) adds one on every clock. The constant-rate counter (address 1) adds one on each cycle with `evt_const` high. The memory-stall counter (address 3) adds one on each cycle with `stall_llc` high.
- R3: While counting runs, the instructions-retired counter (address 2) adds the value of `retire_cnt` (0, 1 or 2) in one step.
- R4: While `wait_st` is 1, no counter changes, except through a granted write.
- R5: While `cnt_en` is 0, no counter advances. A granted read returns `rsp_vld`=1 with `rsp_data`=0.
- R6: Auxiliary counter i sits at address 16+i. It adds one on each counting cycle with `aux_evt[i]` high.
- R7: A request sampled on clock edge t is answered in the cycle after t. A granted read returns the counter value held just before edge t. With no request, the next cycle shows `rsp_vld`=0 and `rsp_fault`=0.
- R8: Level 2 and level 3 (`priv`=2, 3) are always allowed. Level 1 needs `lvl2_en`=1. Level 0 needs both `lvl1_en`=1 and `lvl2_en`=1. A refused request gives `rsp_fault`=1, `rsp_vld`=0 and `rsp_data`=0 in the next cycle.
- R9: Only `priv`=3 may write. A write from any other level is refused as in R8 and leaves the counter unchanged. A granted write is acknowledged with `rsp_vld`=1 and `rsp_data`=0. A granted write takes priority over an increment on the same edge.
- R10: A counter holding all ones wraps to zero on its next increment.
- R11: Addresses 4 to 15, and 16+i for i >= the number of auxiliary counters, are unmapped. A request to one of them faults as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Global counter enable |
| wait_st | input | 1 | Core is in a wait-for-interrupt or wait-for-event state |
| evt_const | input | 1 | Constant-rate tick |
| retire_cnt | input | 2 | Instructions retired this cycle (0 to 2) |
| stall_llc | input | 1 | Dispatch stall caused by a last-level cache miss |
| aux_evt | input | AUX_N | Auxiliary event qualifiers |
| priv | input | 2 | Privilege level of the requester |
| lvl1_en | input | 1 | Level-1 grant of access to level 0 |
| lvl2_en | input | 1 | Level-2 grant of access to the lower levels |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Counter address |
| req_wdata | input | CNT_W | Write data |
| rsp_vld | output | 1 | Granted response |
| rsp_fault | output | 1 | Undefined-access fault strobe |
| rsp_data | output | CNT_W | Read data |

## Verification
A reference model in the bench tracks every counter over long random runs. These runs mix wait states, enable toggles, all privilege levels and delegation settings, and both mapped and unmapped addresses, so that counting, gating and access checking are tested together. Directed sequences then isolate single effects. Retire counts of 0, 1 and 2 separate an adder that steps by one from one that adds the full count. Reads issued across wait periods show the freeze. A write of all ones followed by reads shows the wrap and that the write beats the increment. Writes from levels 2 and 3 separate the write rule from the read rule.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

    localparam int NUM_FIXED = 4;

    typedef enum logic [1:0] {
        FX_CORE  = 2'd0,
        FX_CONST = 2'd1,
        FX_INST  = 2'd2,
        FX_STALL = 2'd3
    } fixed_sel_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_READ  = 2'd1,
        RS_WRITE = 2'd2,
        RS_DENY  = 2'd3
    } rsp_state_e;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_KERN  = 2'd1,
        PL_HYP   = 2'd2,
        PL_FIRM  = 2'd3
    } priv_e;

endpackage

// File: rtl/actmon_counter.sv
module actmon_counter #(
    parameter int CNT_W = 64,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [INC_W-1:0] inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value
);

    // write wins over increment; addition wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end else if (run) begin
            value <= value + CNT_W'(inc);
        end
    end

endmodule

// File: rtl/actmon_access.sv
module actmon_access
    import actmon_pkg::*;
#(
    parameter int AUX_N = 16,
    parameter int IDX_W = 5
) (
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic [4:0]       req_addr,
    input  logic [1:0]       priv,
    input  logic             lvl1_en,
    input  logic             lvl2_en,
    output logic             deny,
    output logic             grant_wr,
    output logic [IDX_W-1:0] idx
);

    logic priv_ok;
    logic wr_ok;
    logic mapped;
    logic is_aux;
    logic [3:0] aux_idx;

    assign is_aux  = req_addr[4];
    assign aux_idx = req_addr[3:0];

    always_comb begin
        unique case (priv_e'(priv))
            PL_USER: priv_ok = lvl1_en && lvl2_en;
            PL_KERN: priv_ok = lvl2_en;
            PL_HYP:  priv_ok = 1'b1;
            PL_FIRM: priv_ok = 1'b1;
            default: priv_ok = 1'b0;
        endcase
    end

    assign wr_ok = (priv_e'(priv) == PL_FIRM);

    always_comb begin
        if (is_aux) begin
            mapped = (int'(aux_idx) < AUX_N);
            idx    = IDX_W'(NUM_FIXED + int'(aux_idx));
        end else begin
            mapped = (req_addr[3:2] == 2'b00);
            idx    = IDX_W'(req_addr[1:0]);
        end
    end

    assign deny     = req_vld && (!mapped || !priv_ok || (req_wr && !wr_ok));
    assign grant_wr = req_vld && req_wr && !deny;

endmodule

// File: rtl/actmon_port.sv
module actmon_port
    import actmon_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic             deny,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] rd_val,
    output logic             rsp_vld,
    output logic             rsp_fault,
    output logic [CNT_W-1:0] rsp_data
);

    rsp_state_e state_q;
    rsp_state_e state_d;
    logic [CNT_W-1:0] data_q;

    // next-state choice from the current request
    always_comb begin
        if (!req_vld) begin
            state_d = RS_IDLE;
        end else if (deny) begin
            state_d = RS_DENY;
        end else if (req_wr) begin
            state_d = RS_WRITE;
        end else begin
            state_d = RS_READ;
        end
    end

    // state register and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= (state_d == RS_READ && cnt_en) ? rd_val : '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        rsp_vld   = 1'b0;
        rsp_fault = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_READ:  begin rsp_vld = 1'b1; rsp_data = data_q; end
            RS_WRITE: rsp_vld = 1'b1;
            RS_DENY:  rsp_fault = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/actmon_bank.sv
module actmon_bank
    import actmon_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int AUX_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wait_st,
    input  logic             evt_const,
    input  logic [1:0]       retire_cnt,
    input  logic             stall_llc,
    input  logic [AUX_N-1:0] aux_evt,
    input  logic [1:0]       priv,
    input  logic             lvl1_en,
    input  logic             lvl2_en,
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic [4:0]       req_addr,
    input  logic [CNT_W-1:0] req_wdata,
    output logic             rsp_vld,
    output logic             rsp_fault,
    output logic [CNT_W-1:0] rsp_data
);

    localparam int NCNT  = NUM_FIXED + AUX_N;
    localparam int IDX_W = $clog2(NCNT);

    logic             run;
    logic             deny;
    logic             grant_wr;
    logic [IDX_W-1:0] acc_idx;
    logic [CNT_W-1:0] cnt_q [NCNT];
    logic [1:0]       fixed_inc [NUM_FIXED];
    logic [CNT_W-1:0] rd_val;

    assign run = cnt_en && !wait_st;

    assign fixed_inc[FX_CORE]  = 2'd1;
    assign fixed_inc[FX_CONST] = {1'b0, evt_const};
    assign fixed_inc[FX_INST]  = retire_cnt;
    assign fixed_inc[FX_STALL] = {1'b0, stall_llc};

    actmon_access #(.AUX_N(AUX_N), .IDX_W(IDX_W)) u_acc (
        .req_vld  (req_vld),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .priv     (priv),
        .lvl1_en  (lvl1_en),
        .lvl2_en  (lvl2_en),
        .deny     (deny),
        .grant_wr (grant_wr),
        .idx      (acc_idx)
    );

    for (genvar gi = 0; gi < NUM_FIXED; gi++) begin : g_fixed
        actmon_counter #(.CNT_W(CNT_W), .INC_W(2)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .inc   (fixed_inc[gi]),
            .wr    (grant_wr && (acc_idx == IDX_W'(gi))),
            .wdata (req_wdata),
            .value (cnt_q[gi])
        );
    end

    for (genvar gj = 0; gj < AUX_N; gj++) begin : g_aux
        actmon_counter #(.CNT_W(CNT_W), .INC_W(1)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .inc   (aux_evt[gj]),
            .wr    (grant_wr && (acc_idx == IDX_W'(NUM_FIXED + gj))),
            .wdata (req_wdata),
            .value (cnt_q[NUM_FIXED + gj])
        );
    end

    assign rd_val = cnt_q[acc_idx];

    actmon_port #(.CNT_W(CNT_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_wr    (req_wr),
        .deny      (deny),
        .cnt_en    (cnt_en),
        .rd_val    (rd_val),
        .rsp_vld   (rsp_vld),
        .rsp_fault (rsp_fault),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/actmon_bank_chk.sv
module actmon_bank_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             wait_st,
    input logic [1:0]       priv,
    input logic             lvl1_en,
    input logic             lvl2_en,
    input logic             req_vld,
    input logic             req_wr,
    input logic [4:0]       req_addr,
    input logic             rsp_vld,
    input logic             rsp_fault,
    input logic [CNT_W-1:0] rsp_data,
    input logic [CNT_W-1:0] core_q
);

    a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_vld && rsp_fault));

    a_r8_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && priv == 2'd0 && !(lvl1_en && lvl2_en) |=> rsp_fault && rsp_data == '0);

    a_r9_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_wr && priv != 2'd3 |=> rsp_fault);

    a_r4_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        wait_st && !(req_vld && req_wr) |=> $stable(core_q));

    a_r2_core_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && !wait_st && !req_vld |=> core_q == $past(core_q) + 1'b1);

    a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !req_wr && !cnt_en |=> rsp_data == '0);

    a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld || rsp_fault);

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld && !rsp_fault);

    a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !req_addr[4] && req_addr[3:2] != 2'b00 |=> rsp_fault);

endmodule

bind actmon_bank actmon_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .wait_st   (wait_st),
    .priv      (priv),
    .lvl1_en   (lvl1_en),
    .lvl2_en   (lvl2_en),
    .req_vld   (req_vld),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .rsp_vld   (rsp_vld),
    .rsp_fault (rsp_fault),
    .rsp_data  (rsp_data),
    .core_q    (cnt_q[0])
);

// File: tb/actmon_bank_test.sv
module actmon_bank_test;

    localparam int PERIOD = 10;
    localparam int CNT_W  = 64;
    localparam int AUX_N  = 16;
    localparam int NCNT   = 4 + AUX_N;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cnt_en, wait_st, evt_const, stall_llc;
    logic [1:0]       retire_cnt;
    logic [AUX_N-1:0] aux_evt;
    logic [1:0]       priv;
    logic             lvl1_en, lvl2_en;
    logic             req_vld, req_wr;
    logic [4:0]       req_addr;
    logic [CNT_W-1:0] req_wdata;
    logic             rsp_vld, rsp_fault;
    logic [CNT_W-1:0] rsp_data;

    int n_chk = 0;
    int n_err = 0;
    logic [CNT_W-1:0] m [NCNT];

    always #(PERIOD/2) clk = ~clk;

    actmon_bank #(.CNT_W(CNT_W), .AUX_N(AUX_N)) uut (.*);

    function automatic logic f_allowed(logic [1:0] p, logic l1, logic l2);
        if (p == 2'd0) return l1 && l2;
        if (p == 2'd1) return l2;
        return 1'b1;
    endfunction

    function automatic logic f_mapped(logic [4:0] a);
        if (a[4]) return int'(a[3:0]) < AUX_N;
        return a[3:2] == 2'b00;
    endfunction

    function automatic int f_index(logic [4:0] a);
        return a[4] ? 4 + int'(a[3:0]) : int'(a[1:0]);
    endfunction

    task automatic chk(string tag, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock with the current inputs; model and response check
    task automatic step(string tag_in);
        logic ok, ev, ef;
        logic [CNT_W-1:0] ed;
        string tag;
        int ix;
        logic run;
        ok  = req_vld && f_mapped(req_addr) && f_allowed(priv, lvl1_en, lvl2_en)
              && !(req_wr && priv != 2'd3);
        ix  = f_index(req_addr);
        ev  = req_vld && ok;
        ef  = req_vld && !ok;
        ed  = (ev && !req_wr && cnt_en) ? m[ix] : '0;
        tag = tag_in;
        if (tag == "") begin
            if (!req_vld)                      tag = "R7";
            else if (!f_mapped(req_addr))      tag = "R11";
            else if (!ok)                      tag = req_wr ? "R9" : "R8";
            else if (!cnt_en && !req_wr)       tag = "R5";
            else                               tag = "R7";
        end
        run = cnt_en && !wait_st;
        for (int i = 0; i < NCNT; i++) begin
            logic [CNT_W-1:0] inc;
            case (i)
                0: inc = 1;
                1: inc = CNT_W'(evt_const);
                2: inc = CNT_W'(retire_cnt);
                3: inc = CNT_W'(stall_llc);
                default: inc = CNT_W'(aux_evt[i-4]);
            endcase
            if (ev && req_wr && ix == i) m[i] = req_wdata;
            else if (run) m[i] = m[i] + inc;
        end
        @(posedge clk);
        #1;
        chk(tag, CNT_W'(rsp_vld), CNT_W'(ev), "rsp_vld");
        chk(tag, CNT_W'(rsp_fault), CNT_W'(ef), "rsp_fault");
        chk(tag, rsp_data, ed, "rsp_data");
        req_vld = 1'b0;
        req_wr  = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [1:0] p, string tag);
        req_vld = 1'b1; req_wr = 1'b0; req_addr = a; priv = p;
        step(tag);
    endtask

    task automatic wr(logic [4:0] a, logic [1:0] p, logic [CNT_W-1:0] d, string tag);
        req_vld = 1'b1; req_wr = 1'b1; req_addr = a; priv = p; req_wdata = d;
        step(tag);
    endtask

    task automatic quiet_events();
        evt_const = 0; retire_cnt = 0; stall_llc = 0; aux_evt = '0; wait_st = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_err++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NCNT; i++) m[i] = '0;
        rst_n = 0; cnt_en = 0; quiet_events();
        priv = 0; lvl1_en = 0; lvl2_en = 0;
        req_vld = 0; req_wr = 0; req_addr = 0; req_wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", CNT_W'(rsp_vld), 0, "rsp_vld at reset");
        chk("R1", CNT_W'(rsp_fault), 0, "rsp_fault at reset");
        chk("R1", rsp_data, 0, "rsp_data at reset");
        rst_n = 1;
        cnt_en = 1;
        rd(5'd1, 2'd3, "R1");
        rd(5'd19, 2'd3, "R1");

        // R2: constant and stall strobes, core every clock
        evt_const = 1; stall_llc = 1;
        repeat (5) step("R2");
        evt_const = 0;
        rd(5'd1, 2'd3, "R2");
        rd(5'd3, 2'd3, "R2");
        rd(5'd0, 2'd3, "R2");
        stall_llc = 0;

        // R3: retire counts 2,1,0
        retire_cnt = 2; step("R3");
        retire_cnt = 1; step("R3");
        retire_cnt = 0; step("R3");
        rd(5'd2, 2'd3, "R3");
        chk("R3", rsp_data, 64'd3, "inst after 2+1+0");

        // R4: wait freezes everything
        wait_st = 1; evt_const = 1; retire_cnt = 2; aux_evt = '1;
        rd(5'd0, 2'd3, "R4");
        repeat (4) step("R4");
        rd(5'd0, 2'd3, "R4");
        rd(5'd2, 2'd3, "R4");
        quiet_events();

        // R5: disabled reads zero, no counting
        cnt_en = 0;
        repeat (3) step("R5");
        rd(5'd0, 2'd3, "R5");
        cnt_en = 1;
        rd(5'd0, 2'd3, "R5");

        // R6: auxiliary counters
        aux_evt = 16'h8001;
        repeat (4) step("R6");
        aux_evt = 16'h0002;
        step("R6");
        aux_evt = '0;
        rd(5'd16, 2'd3, "R6");
        rd(5'd31, 2'd3, "R6");
        rd(5'd17, 2'd2, "R6");

        // R8: privilege checks
        lvl1_en = 1; lvl2_en = 0;
        rd(5'd0, 2'd0, "R8");
        rd(5'd0, 2'd1, "R8");
        lvl1_en = 0; lvl2_en = 1;
        rd(5'd0, 2'd0, "R8");
        rd(5'd0, 2'd1, "R8");
        lvl1_en = 1;
        rd(5'd0, 2'd0, "R8");

        // R9: write rules and priority
        wr(5'd3, 2'd2, 64'hDEAD, "R9");
        rd(5'd3, 2'd3, "R9");
        stall_llc = 1;
        wr(5'd3, 2'd3, 64'h1234, "R9");
        stall_llc = 0;
        rd(5'd3, 2'd3, "R9");
        chk("R9", rsp_data, 64'h1234, "write beats increment");

        // R10: wrap
        wr(5'd0, 2'd3, '1, "R10");
        rd(5'd0, 2'd3, "R10");
        chk("R10", rsp_data, '1, "core holds all ones");
        rd(5'd0, 2'd3, "R10");
        chk("R10", rsp_data, 64'd0, "core wrapped");

        // R11: unmapped
        rd(5'd5, 2'd3, "R11");
        wr(5'd12, 2'd3, 64'h1, "R11");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            cnt_en     = ($urandom_range(0, 9) != 0);
            wait_st    = ($urandom_range(0, 4) == 0);
            evt_const  = $urandom_range(0, 1);
            retire_cnt = 2'($urandom_range(0, 2));
            stall_llc  = ($urandom_range(0, 3) == 0);
            aux_evt    = AUX_N'($urandom);
            lvl1_en    = $urandom_range(0, 1);
            lvl2_en    = $urandom_range(0, 1);
            r = $urandom_range(0, 9);
            if (r < 6) begin
                req_vld  = 1;
                priv     = 2'($urandom_range(0, 3));
                req_wr   = ($urandom_range(0, 7) == 0);
                req_addr = ($urandom_range(0, 9) < 8) ?
                           ($urandom_range(0, 1) ? 5'(16 + $urandom_range(0, 15))
                                                 : 5'($urandom_range(0, 3)))
                           : 5'($urandom_range(4, 15));
                req_wdata = {$urandom, $urandom};
                if ($urandom_range(0, 3) == 0) req_wdata = '1;
            end
            step("");
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule